// File: doc/BRIEF.md
# Grouped-Priority Nested Interrupt Controller

This block arbitrates a parameterised set of external interrupt lines (68 by default) for a processor core. Each line has an enable bit, a pending bit, an active bit and a 4-bit urgency value. A numerically smaller value is more urgent. Software reaches all of this state through a single-cycle word-addressed register bus. Enable and pending each have a set address and a clear address. Active status is read-only. Urgency values are packed one per byte, four lines to a word.

In every cycle the block picks the most urgent line that is enabled, pending and not already active. A 3-bit grouping control divides the urgency into an upper preemption group and a lower sub-order. The block offers the chosen line to the core only when nothing is running, or when the line's group is strictly more urgent than the group of the handler at the top of the nesting record. The core accepts an offer with a take strobe. It signals the end of the innermost handler with a return strobe.

A rising edge on a line makes it pending, whether or not the line is enabled. The line is offered only after it is enabled.

Top module: `irq_nest_ctrl`

## Requirements
- R1: Each line's urgency field sits in bits [7:4] of its byte. Line n is in byte n%4 of priority word 0x20+n/4. Bits [3:0] of every byte read as zero, and writes to them are discarded.
- R2: The enable words are at 0x00+w (set) and 0x04+w (clear), where w covers lines 32w..32w+31. Writing a 1 sets or clears the bit, and writing a 0 leaves it unchanged. Either address reads back the current enable state. Bit positions at or beyond the line count read as zero.
- R3: A 0-to-1 transition on irq_i[n] sets pending bit n even while line n is disabled. The line is offered only once it is enabled.
- R4: The pending words are at 0x08+w (set) and 0x0C+w (clear), with the same write-1 semantics and read-back as R2. A set wins over a clear in the same cycle.
- R5: Among lines that are enabled, pending and not active, the offered line has the smallest urgency value. A tie goes to the lowest line number.
- R6: The grouping control is bits [2:0] of word 0x14. Values 0 to 3 give a 4-bit group, 4 gives 3 bits, 5 gives 2 bits, 6 gives 1 bit and 7 gives no group bits. The sub-order takes the remaining lower bits. A line is offered during a handler only if its group value is strictly smaller than the running handler's group value.
- R7: A take clears the offered line's pending bit and sets its active bit. If a new rising edge on that line arrives in the same cycle, the pending bit stays set.
- R8: A return clears the active bit of the most recently taken handler that is still active. The previous handler's group then governs preemption again.
- R9: The active words at 0x10+w are read-only. Writes to them change nothing.
- R10: After reset, all enable, pending, active, urgency and grouping state reads as zero, and no line is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_IRQ | Interrupt lines, rising edge makes pending |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 6 | Register word address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, combinational from address |
| req_valid_o | output | 1 | A line is offered to the core |
| req_id_o | output | ID_W | Number of the offered line |
| take_i | input | 1 | Core accepts the offered line |
| ret_i | input | 1 | Core returns from the innermost handler |

## Verification
A take and a fresh rising edge on the same line can land in one cycle. The bench raises irq_i for the offered line in exactly the cycle it pulses take_i. It then expects the line's active bit to be set while its pending bit stays 1. It also expects the line to stay unoffered until the return, and to be offered again right after it. The grouping control is judged by holding one handler active and switching the split under a pending rival, so that the same pair of urgencies either blocks or preempts.

// File: rtl/inc_pkg.sv
package inc_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_EN_SET = 6'h00;
    localparam logic [ADDR_W-1:0] A_EN_CLR = 6'h04;
    localparam logic [ADDR_W-1:0] A_PD_SET = 6'h08;
    localparam logic [ADDR_W-1:0] A_PD_CLR = 6'h0C;
    localparam logic [ADDR_W-1:0] A_ACT    = 6'h10;
    localparam logic [ADDR_W-1:0] A_GRP    = 6'h14;
    localparam logic [ADDR_W-1:0] A_PRIO   = 6'h20;

    // number of low urgency bits that belong to the sub-order
    function automatic logic [2:0] sub_width(input logic [2:0] g);
        return (g <= 3'd3) ? 3'd0 : g - 3'd3;
    endfunction

    // preemption group value of a 4-bit urgency under grouping g
    function automatic logic [3:0] group_of(input logic [3:0] p, input logic [2:0] g);
        return p >> sub_width(g);
    endfunction

endpackage

// File: rtl/inc_regs.sv
module inc_regs
    import inc_pkg::*;
#(
    parameter int NUM_IRQ = 68,
    parameter int ID_W    = 7
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [NUM_IRQ-1:0]            irq_i,
    input  logic                          bus_we_i,
    input  logic [ADDR_W-1:0]             bus_addr_i,
    input  logic [DATA_W-1:0]             bus_wdata_i,
    output logic [DATA_W-1:0]             bus_rdata_o,
    input  logic                          take_fire_i,
    input  logic [ID_W-1:0]               take_id_i,
    input  logic                          ret_fire_i,
    input  logic [ID_W-1:0]               ret_id_i,
    output logic [NUM_IRQ-1:0]            en_o,
    output logic [NUM_IRQ-1:0]            pend_o,
    output logic [NUM_IRQ-1:0]            act_o,
    output logic [NUM_IRQ-1:0][3:0]       prio_o,
    output logic [2:0]                    grp_o
);

    typedef struct packed {
        logic [NUM_IRQ-1:0]      en;
        logic [NUM_IRQ-1:0]      pend;
        logic [NUM_IRQ-1:0]      act;
        logic [NUM_IRQ-1:0]      prev;
        logic [NUM_IRQ-1:0][3:0] prio;
        logic [2:0]              grp;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.prev = irq_i;
        if (bus_we_i && bus_addr_i == A_GRP) s_d.grp = bus_wdata_i[2:0];
        for (int i = 0; i < NUM_IRQ; i++) begin
            // enable: write-1-to-set / write-1-to-clear
            if (bus_we_i && bus_wdata_i[i % 32]) begin
                if (bus_addr_i == A_EN_SET + 6'(i / 32)) s_d.en[i] = 1'b1;
                if (bus_addr_i == A_EN_CLR + 6'(i / 32)) s_d.en[i] = 1'b0;
            end
            // pending: clears first, then sets so that a set wins
            if (take_fire_i && take_id_i == ID_W'(i)) s_d.pend[i] = 1'b0;
            if (bus_we_i && bus_wdata_i[i % 32] && bus_addr_i == A_PD_CLR + 6'(i / 32))
                s_d.pend[i] = 1'b0;
            if (bus_we_i && bus_wdata_i[i % 32] && bus_addr_i == A_PD_SET + 6'(i / 32))
                s_d.pend[i] = 1'b1;
            if (irq_i[i] && !s_q.prev[i]) s_d.pend[i] = 1'b1;
            // active: only the core handshake touches it
            if (ret_fire_i && ret_id_i == ID_W'(i))   s_d.act[i] = 1'b0;
            if (take_fire_i && take_id_i == ID_W'(i)) s_d.act[i] = 1'b1;
            // urgency: upper nibble of the line's byte only
            if (bus_we_i && bus_addr_i == A_PRIO + 6'(i / 4))
                s_d.prio[i] = bus_wdata_i[(i % 4) * 8 + 4 +: 4];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == A_GRP) bus_rdata_o[2:0] = s_q.grp;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (bus_addr_i == A_EN_SET + 6'(i / 32) || bus_addr_i == A_EN_CLR + 6'(i / 32))
                bus_rdata_o[i % 32] = s_q.en[i];
            if (bus_addr_i == A_PD_SET + 6'(i / 32) || bus_addr_i == A_PD_CLR + 6'(i / 32))
                bus_rdata_o[i % 32] = s_q.pend[i];
            if (bus_addr_i == A_ACT + 6'(i / 32))
                bus_rdata_o[i % 32] = s_q.act[i];
            if (bus_addr_i == A_PRIO + 6'(i / 4))
                bus_rdata_o[(i % 4) * 8 + 4 +: 4] = s_q.prio[i];
        end
    end

    assign en_o   = s_q.en;
    assign pend_o = s_q.pend;
    assign act_o  = s_q.act;
    assign prio_o = s_q.prio;
    assign grp_o  = s_q.grp;

    // R3: a rising edge on line 0 always leaves it pending in the next cycle
    assert_edge_pends_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_i[0] && !s_q.prev[0]) |=> pend_o[0]);

endmodule

// File: rtl/inc_arb.sv
module inc_arb #(
    parameter int NUM_IRQ = 68,
    parameter int ID_W    = 7
) (
    input  logic [NUM_IRQ-1:0]      cand_i,
    input  logic [NUM_IRQ-1:0][3:0] prio_i,
    output logic                    best_valid_o,
    output logic [ID_W-1:0]         best_id_o,
    output logic [3:0]              best_prio_o
);

    // scan from the top so that on equal urgency the lower number replaces
    always_comb begin
        best_valid_o = 1'b0;
        best_id_o    = '0;
        best_prio_o  = 4'hF;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (cand_i[i] && (!best_valid_o || prio_i[i] <= best_prio_o)) begin
                best_valid_o = 1'b1;
                best_id_o    = ID_W'(i);
                best_prio_o  = prio_i[i];
            end
        end
    end

endmodule

// File: rtl/inc_nest.sv
module inc_nest #(
    parameter int DEPTH = 16,
    parameter int ID_W  = 7,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    input  logic [ID_W-1:0]  push_id_i,
    input  logic [3:0]       push_prio_i,
    input  logic             pop_i,
    output logic             top_valid_o,
    output logic             full_o,
    output logic [ID_W-1:0]  top_id_o,
    output logic [3:0]       top_prio_o,
    output logic [PTR_W-1:0] depth_o
);

    typedef struct packed {
        logic [DEPTH-1:0][ID_W-1:0] id;
        logic [DEPTH-1:0][3:0]      prio;
        logic [PTR_W-1:0]           cnt;
    } nest_t;

    nest_t n_d, n_q;

    always_comb begin
        n_d = n_q;
        if (pop_i && n_q.cnt != '0) begin
            n_d.cnt = n_q.cnt - 1'b1;
        end else if (push_i && n_q.cnt != PTR_W'(DEPTH)) begin
            for (int k = 0; k < DEPTH; k++) begin
                if (PTR_W'(k) == n_q.cnt) begin
                    n_d.id[k]   = push_id_i;
                    n_d.prio[k] = push_prio_i;
                end
            end
            n_d.cnt = n_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) n_q <= '0;
        else         n_q <= n_d;
    end

    always_comb begin
        top_id_o   = '0;
        top_prio_o = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (PTR_W'(k + 1) == n_q.cnt) begin
                top_id_o   = n_q.id[k];
                top_prio_o = n_q.prio[k];
            end
        end
    end

    assign top_valid_o = (n_q.cnt != '0);
    assign full_o      = (n_q.cnt == PTR_W'(DEPTH));
    assign depth_o     = n_q.cnt;

    // R8: an entry pushed becomes the new top in the next cycle
    assert_push_becomes_top_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && !pop_i && !full_o) |=> (top_id_o == $past(push_id_i)));

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import inc_pkg::*;
#(
    parameter int NUM_IRQ   = 68,
    parameter int NEST_DEPTH = 16,
    localparam int ID_W     = $clog2(NUM_IRQ)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_IRQ-1:0]  irq_i,
    input  logic                bus_we_i,
    input  logic [5:0]          bus_addr_i,
    input  logic [31:0]         bus_wdata_i,
    output logic [31:0]         bus_rdata_o,
    output logic                req_valid_o,
    output logic [ID_W-1:0]     req_id_o,
    input  logic                take_i,
    input  logic                ret_i
);

    localparam int PTR_W = $clog2(NEST_DEPTH + 1);

    logic [NUM_IRQ-1:0]      en_w, pend_w, act_w;
    logic [NUM_IRQ-1:0][3:0] prio_w;
    logic [2:0]              grp_w;
    logic                    best_valid, top_valid, nest_full;
    logic [ID_W-1:0]         best_id, top_id;
    logic [3:0]              best_prio, top_prio;
    logic [PTR_W-1:0]        depth_w;
    logic                    take_fire, ret_fire;

    inc_regs #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .irq_i       (irq_i),
        .bus_we_i    (bus_we_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .take_fire_i (take_fire),
        .take_id_i   (best_id),
        .ret_fire_i  (ret_fire),
        .ret_id_i    (top_id),
        .en_o        (en_w),
        .pend_o      (pend_w),
        .act_o       (act_w),
        .prio_o      (prio_w),
        .grp_o       (grp_w)
    );

    inc_arb #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) u_arb (
        .cand_i       (en_w & pend_w & ~act_w),
        .prio_i       (prio_w),
        .best_valid_o (best_valid),
        .best_id_o    (best_id),
        .best_prio_o  (best_prio)
    );

    inc_nest #(.DEPTH(NEST_DEPTH), .ID_W(ID_W)) u_nest (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .push_i      (take_fire),
        .push_id_i   (best_id),
        .push_prio_i (best_prio),
        .pop_i       (ret_fire),
        .top_valid_o (top_valid),
        .full_o      (nest_full),
        .top_id_o    (top_id),
        .top_prio_o  (top_prio),
        .depth_o     (depth_w)
    );

    // preemption: strictly more urgent group than the running handler
    assign req_valid_o = best_valid && !nest_full &&
                         (!top_valid || group_of(best_prio, grp_w) < group_of(top_prio, grp_w));
    assign req_id_o    = best_id;
    assign ret_fire    = ret_i && top_valid;
    assign take_fire   = take_i && req_valid_o && !ret_i;

    // R5: only an enabled, pending, inactive line is offered
    assert_offer_eligible_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_o |-> (en_w[req_id_o] && pend_w[req_id_o] && !act_w[req_id_o]));

    // R7: a take marks the taken line active
    assert_take_sets_active_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_fire |=> act_w[$past(best_id)]);

    // R8: a return retires the innermost handler
    assert_ret_clears_active_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ret_fire |=> !act_w[$past(top_id)]);

    // R8: active bits and nesting record stay in step
    assert_active_matches_depth_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(act_w) == int'(depth_w));

    // R9: bus writes alone never change active state
    assert_active_ro_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!take_fire && !ret_fire) |=> $stable(act_w));

endmodule

// File: tb/tb_irq_nest_ctrl.sv
module tb_irq_nest_ctrl;

    localparam int NUM_IRQ = 68;
    localparam int ID_W    = $clog2(NUM_IRQ);

    logic               clk = 1'b0;
    logic               rst_ni = 1'b0;
    logic [NUM_IRQ-1:0] irq = '0;
    logic               bus_we = 1'b0;
    logic [5:0]         bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic               req_valid;
    logic [ID_W-1:0]    req_id;
    logic               take = 1'b0;
    logic               ret = 1'b0;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    irq_nest_ctrl dut (
        .clk_i       (clk),
        .rst_ni      (rst_ni),
        .irq_i       (irq),
        .bus_we_i    (bus_we),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .req_valid_o (req_valid),
        .req_id_o    (req_id),
        .take_i      (take),
        .ret_i       (ret)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1 chk(tag, bus_rdata, exp);
    endtask

    task automatic req_chk(input string tag, input logic v, input int id);
        @(negedge clk);
        #1;
        chk({tag, " valid"}, 32'(req_valid), 32'(v));
        if (v) chk({tag, " id"}, 32'(req_id), 32'(id));
    endtask

    task automatic do_take();
        @(negedge clk); take = 1'b1;
        @(negedge clk); take = 1'b0;
    endtask

    task automatic do_ret();
        @(negedge clk); ret = 1'b1;
        @(negedge clk); ret = 1'b0;
    endtask

    task automatic pulse_irq(input int n);
        @(negedge clk); irq[n] = 1'b1;
        @(negedge clk); irq[n] = 1'b0;
    endtask

    task automatic clean();
        for (int w = 0; w < 3; w++) begin
            wr(6'h04 + 6'(w), 32'hFFFF_FFFF);
            wr(6'h0C + 6'(w), 32'hFFFF_FFFF);
        end
    endtask

    task automatic t_reset();
        rd_chk("R10 enable w0", 6'h00, 32'h0);
        rd_chk("R10 pending w2", 6'h0A, 32'h0);
        rd_chk("R10 prio w16", 6'h30, 32'h0);
        rd_chk("R10 grouping", 6'h14, 32'h0);
        req_chk("R10 no offer", 1'b0, 0);
    endtask

    task automatic t_prio();
        wr(6'h20, 32'hFFFF_FFFF);
        rd_chk("R1 low nibbles drop", 6'h20, 32'hF0F0_F0F0);
        wr(6'h30, 32'h1234_5678);
        rd_chk("R1 last word lines 64-67", 6'h30, 32'h1030_5070);
        wr(6'h20, 32'h0);
        wr(6'h30, 32'h0);
    endtask

    task automatic t_enable();
        wr(6'h00, 32'h5);
        rd_chk("R2 set read", 6'h00, 32'h5);
        rd_chk("R2 clear addr read", 6'h04, 32'h5);
        wr(6'h00, 32'h0);
        rd_chk("R2 zero write no effect", 6'h00, 32'h5);
        wr(6'h04, 32'h1);
        rd_chk("R2 clear one bit", 6'h00, 32'h4);
        wr(6'h02, 32'hFFFF_FFFF);
        rd_chk("R2 beyond line count", 6'h02, 32'h0000_000F);
        clean();
    endtask

    task automatic t_pending_active();
        wr(6'h09, 32'h3);
        rd_chk("R4 set read", 6'h0D, 32'h3);
        wr(6'h0D, 32'h1);
        rd_chk("R4 clear one bit", 6'h09, 32'h2);
        req_chk("R4 disabled not offered", 1'b0, 0);
        wr(6'h10, 32'hFFFF_FFFF);
        rd_chk("R9 active ignores write", 6'h10, 32'h0);
        clean();
    endtask

    task automatic t_edge();
        pulse_irq(10);
        rd_chk("R3 edge pends while disabled", 6'h08, 32'h0000_0400);
        req_chk("R3 disabled waits", 1'b0, 0);
        wr(6'h00, 32'h0000_0400);
        req_chk("R3 offered after enable", 1'b1, 10);
        clean();
    endtask

    task automatic t_select();
        wr(6'h14, 32'h3);
        wr(6'h20, 32'h4000_0000);    // line 3 = 4
        wr(6'h21, 32'h2000_0000);    // line 7 = 2
        wr(6'h2A, 32'h0000_0020);    // line 40 = 2
        wr(6'h00, 32'h88); wr(6'h01, 32'h100);
        wr(6'h08, 32'h88); wr(6'h09, 32'h100);
        req_chk("R5 lowest value, lowest id", 1'b1, 7);
        do_take();
        rd_chk("R7 active set", 6'h10, 32'h80);
        rd_chk("R7 pending cleared", 6'h08, 32'h08);
        req_chk("R6 equal group waits", 1'b0, 0);
        do_ret();
        rd_chk("R8 active cleared", 6'h10, 32'h0);
        req_chk("R5 tie partner next", 1'b1, 40);
        do_take(); do_ret();
        req_chk("R5 least urgent last", 1'b1, 3);
        do_take(); do_ret();
        req_chk("R5 nothing left", 1'b0, 0);
        wr(6'h20, 0); wr(6'h21, 0); wr(6'h2A, 0);
        clean();
    endtask

    task automatic t_group();
        wr(6'h20, 32'h00F0_0000);    // line 2 = 15, line 1 = 0
        wr(6'h14, 32'h7);
        wr(6'h00, 32'h6);
        wr(6'h08, 32'h4);
        req_chk("R6 idle offer", 1'b1, 2);
        do_take();
        wr(6'h08, 32'h2);
        req_chk("R6 no group bits blocks", 1'b0, 0);
        wr(6'h14, 32'h4);
        req_chk("R6 three group bits preempt", 1'b1, 1);
        do_take();
        rd_chk("R8 nested active", 6'h10, 32'h6);
        do_ret();
        rd_chk("R8 inner retired first", 6'h10, 32'h4);
        do_ret();
        rd_chk("R8 all retired", 6'h10, 32'h0);
        wr(6'h20, 0);
        clean();
        wr(6'h25, 32'h0000_4050);    // line 20 = 5, line 21 = 4
        wr(6'h14, 32'h3);
        wr(6'h00, 32'h0030_0000);
        wr(6'h08, 32'h0010_0000);
        req_chk("R6 first handler", 1'b1, 20);
        do_take();
        wr(6'h08, 32'h0020_0000);
        wr(6'h14, 32'h5);
        req_chk("R6 two group bits equal", 1'b0, 0);
        wr(6'h14, 32'h3);
        req_chk("R6 four group bits preempt", 1'b1, 21);
        do_take(); do_ret(); do_ret();
        rd_chk("R8 nest unwound", 6'h10, 32'h0);
        wr(6'h25, 0);
        clean();
    endtask

    task automatic t_same_cycle();
        wr(6'h00, 32'h0000_1000);
        pulse_irq(12);
        req_chk("R7 line offered", 1'b1, 12);
        @(negedge clk); take = 1'b1; irq[12] = 1'b1;
        @(negedge clk); take = 1'b0; irq[12] = 1'b0;
        rd_chk("R7 taken active", 6'h10, 32'h0000_1000);
        rd_chk("R7 edge keeps pending", 6'h08, 32'h0000_1000);
        req_chk("R7 active not re-offered", 1'b0, 0);
        do_ret();
        req_chk("R8 re-offered after return", 1'b1, 12);
        clean();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        t_reset();
        t_prio();
        t_enable();
        t_pending_active();
        t_edge();
        t_select();
        t_group();
        t_same_cycle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule